// File: doc/BRIEF.md
# SPI Flash Command Framing Decoder

This block is the serial front end of a serial-flash slave model. It oversamples the chip-select, serial clock and serial data input lines with a system clock. Whenever chip select is low, it takes one bit on each rising edge of the serial clock. This works the same way whether the serial clock idles low (mode 0) or high (mode 3). Bits are assembled most significant first into bytes. The first byte of a frame is the opcode, which is looked up in a fixed command table.

The table tells the decoder how many address bytes and dummy bytes follow, and whether a data phase comes after them. The decoder then walks the frame through those phases. It reports:
- the command class;
- the 24-bit address once it is complete;
- a strobe for each data-phase byte, with its value and a saturating byte count;
- an enable that says the slave may drive its serial output (read-type data phases only).

When chip select rises, it reports whether the frame ended on a whole byte with at least the opcode received. The memory array, protection and program/erase timing belong to other blocks.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Bits are taken from `si` on each rising `sck` edge seen while `cs_n` is low, most significant bit first, for both opcode and address. A frame gives identical results whether `sck` idles low or high.
- R2: `cmd_class_o` takes these codes:
  - 1: opcodes 03h, 0Bh, 1Bh
  - 2: 3Bh
  - 3: 20h
  - 4: 52h
  - 5: D8h
  - 6: 60h, C7h
  - 7: 02h
  - 8: A2h
  - 9: 9Fh
  - 10: 06h
  - 11: 04h
  - 12: B9h
  - 13: ABh
  - 14: F0h
  - 0: after reset
  - 15: any other opcode

  `cmd_valid_o` pulses once per frame for a known opcode.
- R3: An opcode not in the table pulses `cmd_invalid_o` (never together with `cmd_valid_o`). The rest of that frame produces no address, no data strobe and no output enable.
- R4: Classes 1, 2, 3, 4, 5, 7 and 8 take three address bytes. `addr_valid_o` pulses after the third byte, and `addr_o` then holds the first address byte in bits 23:16. No other class pulses `addr_valid_o`.
- R5: Dummy bytes sit between address and data: two for 1Bh, one each for 0Bh and 3Bh, and none for 03h.
- R6: In the data phase of classes 1, 2, 7, 8 and 9, each byte pulses `data_strobe_o`, with its value on `data_byte_o` and its 1-based ordinal on `data_count_o`. Class 9 has no address, so its data starts at the second byte.
- R7: Opcodes 60h and C7h both give class 6. Every byte after the opcode is ignored.
- R8: Classes 3, 4, 5 and 10 to 14 never pulse `data_strobe_o`, whatever follows them.
- R9: One cycle after `cs_n` rises, `frame_end_o` pulses for one cycle. `frame_aligned_o` is then 1 exactly when the bits clocked in are a nonzero multiple of 8.
- R10: Every frame starts from an empty bit count. A frame that follows a cut-off frame decodes normally.
- R11: `so_en_o` is high only in the data phase of classes 1, 2 and 9. It is never high for program or erase classes, and it drops when `cs_n` rises.
- R12: After reset, all pulses, `so_en_o`, `frame_aligned_o`, `addr_o`, `data_count_o` and `cmd_class_o` are 0.
- R13: `data_count_o` saturates at its all-ones value (2^CNT_W - 1) while strobes continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, oversamples the serial lines |
| rst_n | input | 1 | synchronous reset, active low |
| cs_n | input | 1 | chip select, active low |
| sck | input | 1 | serial clock |
| si | input | 1 | serial data in |
| cmd_valid_o | output | 1 | pulse: known opcode received |
| cmd_invalid_o | output | 1 | pulse: unknown opcode received |
| cmd_class_o | output | 4 | decoded command class |
| addr_valid_o | output | 1 | pulse: address complete |
| addr_o | output | 8*ADDR_BYTES | assembled address |
| data_strobe_o | output | 1 | pulse: one data-phase byte |
| data_byte_o | output | 8 | value of that byte |
| data_count_o | output | CNT_W | saturating data byte ordinal |
| so_en_o | output | 1 | slave may drive serial output |
| frame_end_o | output | 1 | pulse: chip select rose |
| frame_aligned_o | output | 1 | last frame ended on a byte boundary |

## Verification
The embedded properties are checked on every cycle. They cover:
- no valid and invalid verdict together;
- no strobe, address pulse or output enable for a class that may not have one;
- quiet outputs and a cleared bit count while chip select is high;
- a frame end only after chip select was high.

The exact position of the first data byte after address and dummy bytes cannot be seen by these properties, and neither can the address value, the opcode-to-class map, the alignment verdict or counter saturation. Only the bench scenarios show these: a sweep of all 256 opcodes over seven-byte frames in alternating clock polarity, plus cut-off frames and a long program burst.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [3:0] {
    CLS_NONE         = 4'd0,
    CLS_READ         = 4'd1,
    CLS_DUAL_READ    = 4'd2,
    CLS_ERASE_4K     = 4'd3,
    CLS_ERASE_32K    = 4'd4,
    CLS_ERASE_64K    = 4'd5,
    CLS_CHIP_ERASE   = 4'd6,
    CLS_PROGRAM      = 4'd7,
    CLS_DUAL_PROGRAM = 4'd8,
    CLS_READ_ID      = 4'd9,
    CLS_WR_ENABLE    = 4'd10,
    CLS_WR_DISABLE   = 4'd11,
    CLS_SLEEP        = 4'd12,
    CLS_WAKE         = 4'd13,
    CLS_SOFT_RESET   = 4'd14,
    CLS_INVALID      = 4'd15
  } cmd_class_e;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_ADDR, PH_DUMMY, PH_DATA, PH_IGNORE
  } phase_e;

  typedef struct packed {
    logic       known;
    cmd_class_e cls;
    logic       takes_addr;
    logic [1:0] dummy;
    logic       takes_data;
    logic       drives_out;
  } cmd_info_t;

  // Command table: class, address presence, dummy count, data phase, output drive.
  function automatic cmd_info_t lookup_cmd(input logic [7:0] op);
    cmd_info_t r;
    r.known      = 1'b1;
    r.cls        = CLS_INVALID;
    r.takes_addr = 1'b0;
    r.dummy      = 2'd0;
    r.takes_data = 1'b0;
    r.drives_out = 1'b0;
    case (op)
      8'h03: begin r.cls = CLS_READ; r.takes_addr = 1'b1; r.takes_data = 1'b1; r.drives_out = 1'b1; end
      8'h0B: begin r.cls = CLS_READ; r.takes_addr = 1'b1; r.dummy = 2'd1; r.takes_data = 1'b1; r.drives_out = 1'b1; end
      8'h1B: begin r.cls = CLS_READ; r.takes_addr = 1'b1; r.dummy = 2'd2; r.takes_data = 1'b1; r.drives_out = 1'b1; end
      8'h3B: begin r.cls = CLS_DUAL_READ; r.takes_addr = 1'b1; r.dummy = 2'd1; r.takes_data = 1'b1; r.drives_out = 1'b1; end
      8'h20: begin r.cls = CLS_ERASE_4K;  r.takes_addr = 1'b1; end
      8'h52: begin r.cls = CLS_ERASE_32K; r.takes_addr = 1'b1; end
      8'hD8: begin r.cls = CLS_ERASE_64K; r.takes_addr = 1'b1; end
      8'h60, 8'hC7: r.cls = CLS_CHIP_ERASE;
      8'h02: begin r.cls = CLS_PROGRAM;      r.takes_addr = 1'b1; r.takes_data = 1'b1; end
      8'hA2: begin r.cls = CLS_DUAL_PROGRAM; r.takes_addr = 1'b1; r.takes_data = 1'b1; end
      8'h9F: begin r.cls = CLS_READ_ID; r.takes_data = 1'b1; r.drives_out = 1'b1; end
      8'h06: r.cls = CLS_WR_ENABLE;
      8'h04: r.cls = CLS_WR_DISABLE;
      8'hB9: r.cls = CLS_SLEEP;
      8'hAB: r.cls = CLS_WAKE;
      8'hF0: r.cls = CLS_SOFT_RESET;
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

  function automatic phase_e phase_after_opcode(input cmd_info_t c);
    if (!c.known)          return PH_IGNORE;
    else if (c.takes_addr) return PH_ADDR;
    else if (c.takes_data) return PH_DATA;
    else                   return PH_IGNORE;
  endfunction

  function automatic phase_e phase_after_addr(input cmd_info_t c);
    if (c.dummy != 2'd0)   return PH_DUMMY;
    else if (c.takes_data) return PH_DATA;
    else                   return PH_IGNORE;
  endfunction

endpackage

// File: rtl/spi_edge_shifter.sv
module spi_edge_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            si,
  output logic            cs_rise,
  output logic            byte_done,
  output logic [BITS-1:0] byte_val,
  output logic            aligned_now
);
  localparam int IDX_W = $clog2(BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);

  logic             sck_q, cs_q, got_byte;
  logic [IDX_W-1:0] bit_idx;
  logic [BITS-2:0]  shreg;
  logic             sck_rise;

  // Named edge events
  assign sck_rise    = sck & ~sck_q & ~cs_n;
  assign cs_rise     = cs_n & ~cs_q;
  assign byte_done   = sck_rise && (bit_idx == LAST_IDX);
  assign byte_val    = {shreg, si};
  assign aligned_now = got_byte && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q    <= 1'b1;
      cs_q     <= 1'b1;
      bit_idx  <= '0;
      shreg    <= '0;
      got_byte <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bit_idx  <= '0;
        got_byte <= 1'b0;
      end else if (sck_rise) begin
        bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
        shreg   <= {shreg[BITS-3:0], si};
        if (bit_idx == LAST_IDX) got_byte <= 1'b1;
      end
    end
  end

  // R10: bit counter is empty whenever chip select was high
  assert_bits_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (bit_idx == '0 && !got_byte));

  // R1: a completed byte leaves the counter at a byte boundary
  assert_byte_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (bit_idx == '0 && got_byte));

endmodule

// File: rtl/spi_phase_ctrl.sv
module spi_phase_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    cs_rise,
  input  logic                    byte_done,
  input  logic [7:0]              byte_val,
  input  logic                    aligned_now,
  output logic                    cmd_valid_o,
  output logic                    cmd_invalid_o,
  output logic [3:0]              cmd_class_o,
  output logic                    addr_valid_o,
  output logic [ADDR_BYTES*8-1:0] addr_o,
  output logic                    data_strobe_o,
  output logic [7:0]              data_byte_o,
  output logic [CNT_W-1:0]        data_count_o,
  output logic                    so_en_o,
  output logic                    frame_end_o,
  output logic                    frame_aligned_o
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int REM_W  = (ADDR_BYTES > 4) ? $clog2(ADDR_BYTES) : 2;

  phase_e           phase;
  cmd_info_t        info;
  cmd_info_t        dec;
  phase_e           ph_after_op, ph_after_ad;
  logic [REM_W-1:0] remain;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  assign dec         = lookup_cmd(byte_val);
  assign ph_after_op = phase_after_opcode(dec);
  assign ph_after_ad = phase_after_addr(info);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase           <= PH_OPCODE;
      info            <= '0;
      remain          <= '0;
      cmd_valid_o     <= 1'b0;
      cmd_invalid_o   <= 1'b0;
      cmd_class_o     <= CLS_NONE;
      addr_valid_o    <= 1'b0;
      addr_o          <= '0;
      data_strobe_o   <= 1'b0;
      data_byte_o     <= '0;
      data_count_o    <= '0;
      so_en_o         <= 1'b0;
      frame_end_o     <= 1'b0;
      frame_aligned_o <= 1'b0;
    end else begin
      cmd_valid_o   <= 1'b0;
      cmd_invalid_o <= 1'b0;
      addr_valid_o  <= 1'b0;
      data_strobe_o <= 1'b0;
      frame_end_o   <= cs_rise;
      if (cs_rise) frame_aligned_o <= aligned_now;
      if (cs_n) begin
        phase   <= PH_OPCODE;
        so_en_o <= 1'b0;
      end else if (byte_done) begin
        case (phase)
          PH_OPCODE: begin
            info          <= dec;
            cmd_class_o   <= dec.cls;
            cmd_valid_o   <= dec.known;
            cmd_invalid_o <= !dec.known;
            phase         <= ph_after_op;
            remain        <= REM_W'(ADDR_BYTES - 1);
            data_count_o  <= '0;
            if (ph_after_op == PH_DATA) so_en_o <= dec.drives_out;
          end
          PH_ADDR: begin
            addr_o <= {addr_o[ADDR_W-9:0], byte_val};
            if (remain == '0) begin
              addr_valid_o <= 1'b1;
              phase        <= ph_after_ad;
              remain       <= REM_W'(info.dummy) - 1'b1;
              if (ph_after_ad == PH_DATA) so_en_o <= info.drives_out;
            end else begin
              remain <= remain - 1'b1;
            end
          end
          PH_DUMMY: begin
            if (remain == '0) begin
              phase   <= PH_DATA;
              so_en_o <= info.drives_out;
            end else begin
              remain <= remain - 1'b1;
            end
          end
          PH_DATA: begin
            data_strobe_o <= 1'b1;
            data_byte_o   <= byte_val;
            data_count_o  <= sat_inc(data_count_o);
          end
          default: ;
        endcase
      end
    end
  end

  // R3: one verdict per opcode
  assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && cmd_invalid_o));

  // R6 / R8: data strobes only for classes with a data phase
  assert_strobe_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe_o |-> (cmd_class_o inside {CLS_READ, CLS_DUAL_READ, CLS_PROGRAM,
                                           CLS_DUAL_PROGRAM, CLS_READ_ID}));

  // R11: output drive only for read-type classes
  assert_no_drive_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    so_en_o |-> (cmd_class_o inside {CLS_READ, CLS_DUAL_READ, CLS_READ_ID}));

  // R4: address pulse only for addressed classes
  assert_addr_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> (cmd_class_o inside {CLS_READ, CLS_DUAL_READ, CLS_ERASE_4K,
                      CLS_ERASE_32K, CLS_ERASE_64K, CLS_PROGRAM, CLS_DUAL_PROGRAM}));

  // R9: frame end only follows chip select high
  assert_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> $past(cs_n));

  // R10: nothing decoded while chip select was high
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !(data_strobe_o || addr_valid_o || cmd_valid_o || cmd_invalid_o));

  // R13: a strobed byte always carries a nonzero count
  assert_count_nonzero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe_o |-> (data_count_o != '0));

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    si,
  output logic                    cmd_valid_o,
  output logic                    cmd_invalid_o,
  output logic [3:0]              cmd_class_o,
  output logic                    addr_valid_o,
  output logic [ADDR_BYTES*8-1:0] addr_o,
  output logic                    data_strobe_o,
  output logic [7:0]              data_byte_o,
  output logic [CNT_W-1:0]        data_count_o,
  output logic                    so_en_o,
  output logic                    frame_end_o,
  output logic                    frame_aligned_o
);
  logic       cs_rise, byte_done, aligned_now;
  logic [7:0] byte_val;

  spi_edge_shifter #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_rise(cs_rise), .byte_done(byte_done), .byte_val(byte_val),
    .aligned_now(aligned_now)
  );

  spi_phase_ctrl #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_rise(cs_rise),
    .byte_done(byte_done), .byte_val(byte_val), .aligned_now(aligned_now),
    .cmd_valid_o(cmd_valid_o), .cmd_invalid_o(cmd_invalid_o),
    .cmd_class_o(cmd_class_o), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
    .data_strobe_o(data_strobe_o), .data_byte_o(data_byte_o),
    .data_count_o(data_count_o), .so_en_o(so_en_o),
    .frame_end_o(frame_end_o), .frame_aligned_o(frame_aligned_o)
  );

endmodule

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic cmd_valid_o, cmd_invalid_o, addr_valid_o, data_strobe_o, so_en_o;
  logic frame_end_o, frame_aligned_o;
  logic [3:0]    cmd_class_o;
  logic [23:0]   addr_o;
  logic [7:0]    data_byte_o;
  logic [CW-1:0] data_count_o;

  always #5 clk = ~clk;

  spi_cmd_decoder #(.ADDR_BYTES(3), .CNT_W(CW)) u_spi_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cmd_valid_o(cmd_valid_o), .cmd_invalid_o(cmd_invalid_o),
    .cmd_class_o(cmd_class_o), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
    .data_strobe_o(data_strobe_o), .data_byte_o(data_byte_o),
    .data_count_o(data_count_o), .so_en_o(so_en_o),
    .frame_end_o(frame_end_o), .frame_aligned_o(frame_aligned_o)
  );

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // Port monitor
  int m_valid, m_invalid, m_addrv, m_strobes, m_soen, m_fend;
  int m_cls, m_addr, m_lastbyte, m_lastcnt, m_aligned;
  logic [7:0] fr [0:31];

  always @(posedge clk) begin
    cycles++;
    if (cmd_valid_o)   begin m_valid++; m_cls = int'(cmd_class_o); end
    if (cmd_invalid_o) begin m_invalid++; m_cls = int'(cmd_class_o); end
    if (addr_valid_o)  begin m_addrv++; m_addr = int'(addr_o); end
    if (data_strobe_o) begin m_strobes++; m_lastbyte = int'(data_byte_o); m_lastcnt = int'(data_count_o); end
    if (so_en_o)       m_soen++;
    if (frame_end_o)   begin m_fend++; m_aligned = int'(frame_aligned_o); end
    if (cycles > 190000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_mon();
    m_valid = 0; m_invalid = 0; m_addrv = 0; m_strobes = 0; m_soen = 0; m_fend = 0;
    m_cls = -1; m_addr = -1; m_lastbyte = -1; m_lastcnt = -1; m_aligned = -1;
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Send n whole bytes from fr[], then extra bits of fr[n]; m3 selects idle-high sck.
  task automatic run_frame(input int n, input int extra, input bit m3);
    clear_mon();
    @(negedge clk); sck = m3;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n + 1; k++) begin
      for (int i = 7; i >= 0; i--) begin
        if (k == n && (7 - i) >= extra) break;
        sck = 1'b0; si = fr[k][i];
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
      end
    end
    sck = m3;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int exp_cls(input int op);
    case (op)
      8'h03, 8'h0B, 8'h1B: return 1;
      8'h3B: return 2;
      8'h20: return 3;
      8'h52: return 4;
      8'hD8: return 5;
      8'h60, 8'hC7: return 6;
      8'h02: return 7;
      8'hA2: return 8;
      8'h9F: return 9;
      8'h06: return 10;
      8'h04: return 11;
      8'hB9: return 12;
      8'hAB: return 13;
      8'hF0: return 14;
      default: return 15;
    endcase
  endfunction

  function automatic int exp_dummy(input int op);
    if (op == 8'h1B) return 2;
    if (op == 8'h0B || op == 8'h3B) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] fbyte(input int op, input int k);
    return (k == 0) ? 8'(op) : 8'(op * 7 + k * 29 + 3);
  endfunction

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12: reset state
    check_eq("R12 class after reset", int'(cmd_class_o), 0);
    check_eq("R12 pulses after reset", int'({cmd_valid_o, cmd_invalid_o, addr_valid_o,
             data_strobe_o, frame_end_o}), 0);
    check_eq("R12 so_en/aligned after reset", int'({so_en_o, frame_aligned_o}), 0);
    check_eq("R12 addr/count after reset", int'(addr_o) + int'(data_count_o), 0);

    // Sweep every opcode over a seven-byte frame, alternating sck idle level (R1)
    for (int op = 0; op < 256; op++) begin
      int cls, a, d, has_data, drives, strobes;
      string tag;
      for (int k = 0; k < 8; k++) fr[k] = fbyte(op, k);
      run_frame(7, 0, op[0]);
      cls      = exp_cls(op);
      a        = (cls inside {1, 2, 3, 4, 5, 7, 8}) ? 3 : 0;
      d        = exp_dummy(op);
      has_data = (cls inside {1, 2, 7, 8, 9}) ? 1 : 0;
      drives   = (cls inside {1, 2, 9}) ? 1 : 0;
      strobes  = has_data ? 7 - (1 + a + d) : 0;
      check_eq($sformatf("R2 class op=%02h (R1 mode)", op), m_cls, cls);
      if (cls == 15) begin
        check_eq($sformatf("R3 invalid verdict op=%02h", op), m_invalid * 2 + m_valid, 2);
      end else begin
        check_eq($sformatf("R2 valid verdict op=%02h", op), m_invalid * 2 + m_valid, 1);
      end
      check_eq($sformatf("R4 addr pulses op=%02h", op), m_addrv, (a > 0) ? 1 : 0);
      if (a > 0)
        check_eq($sformatf("R4 addr value op=%02h (R1 msb first)", op), m_addr,
                 int'({fr[1], fr[2], fr[3]}));
      if (op == 8'h1B || op == 8'h0B || op == 8'h3B || op == 8'h03) tag = "R5";
      else if (cls == 6) tag = "R7";
      else if (cls == 15) tag = "R3";
      else if (has_data == 0) tag = "R8";
      else tag = "R6";
      check_eq($sformatf("%s strobes op=%02h", tag, op), m_strobes, strobes);
      if (strobes > 0) begin
        check_eq($sformatf("R6 last byte op=%02h", op), m_lastbyte, int'(fr[6]));
        check_eq($sformatf("R6 last count op=%02h", op), m_lastcnt, strobes);
      end
      check_eq($sformatf("R11 so_en seen op=%02h", op), (m_soen > 0) ? 1 : 0, drives);
      check_eq($sformatf("R9 aligned op=%02h", op), m_aligned, 1);
    end

    // R9: opcode plus three stray bits -> misaligned
    fr[0] = 8'h06; fr[1] = 8'hE0;
    run_frame(1, 3, 1'b0);
    check_eq("R9 frame_end pulses", m_fend, 1);
    check_eq("R9 misaligned frame", m_aligned, 0);
    check_eq("R9 opcode still decoded", m_valid, 1);

    // R9/R10: cut-off opcode, then a normal frame
    fr[0] = 8'h03;
    run_frame(0, 5, 1'b1);
    check_eq("R9 partial opcode aligned", m_aligned, 0);
    check_eq("R10 partial opcode no verdict", m_valid + m_invalid, 0);
    run_frame(0, 0, 1'b0);
    check_eq("R9 empty frame aligned", m_aligned, 0);
    fr[0] = 8'h03; fr[1] = 8'h12; fr[2] = 8'h34; fr[3] = 8'h56; fr[4] = 8'hA5; fr[5] = 8'h5A;
    run_frame(6, 0, 1'b0);
    check_eq("R10 address after cut frame", m_addr, 24'h123456);
    check_eq("R10 strobes after cut frame", m_strobes, 2);
    check_eq("R10 aligned after cut frame", m_aligned, 1);
    run_frame(6, 0, 1'b1);
    check_eq("R1 idle-high address", m_addr, 24'h123456);
    check_eq("R1 idle-high last byte", m_lastbyte, 8'h5A);

    // R13: long program burst saturates the count
    fr[0] = 8'h02; fr[1] = 8'h00; fr[2] = 8'h01; fr[3] = 8'h02;
    for (int k = 4; k < 24; k++) fr[k] = 8'(k * 3);
    run_frame(24, 0, 1'b0);
    check_eq("R13 strobes in burst", m_strobes, 20);
    check_eq("R13 saturated count", m_lastcnt, (1 << CW) - 1);
    check_eq("R11 program never drives", m_soen, 0);

    // R7: C7h followed by many bytes stays quiet
    fr[0] = 8'hC7;
    for (int k = 1; k < 12; k++) fr[k] = 8'hFF;
    run_frame(12, 0, 1'b1);
    check_eq("R7 chip erase class", m_cls, 6);
    check_eq("R7 trailing bytes ignored", m_strobes + m_addrv, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule